// File: doc/BRIEF.md
# Serial Port with Merged Rate and Framing Control

This block is a full-duplex asynchronous serial port on a small memory-mapped register window. A single control word carries both the bit-rate divisor and every framing choice (character length, parity, stop-bit count, FIFO use and a forced break). A second address is the data port: a write queues one character for transmission, and a read takes the oldest received character out of the receive queue. Each received character carries its own error flags, which travel through the queue in the bits above the character.

The reference clock is the block clock. With a divisor value N, one bit lasts 16 × (N + 1) clock cycles. The receiver oversamples the line at sixteen times the bit rate, checks the start bit at its centre, and then samples every following bit at its centre. Both queues hold sixteen characters. When FIFO use is switched off, each queue holds a single character. Software or a sequencer polls the three status outputs, or reacts to the two interrupt lines, and keeps the port switched on through the enable input.

Top module: `uart_shared_cfg`

## Requirements
- R1: The control word is at byte address 0x40 and the data port is at 0x00. A control read returns the stored bits [18:0] and zero in bits [31:19].
- R2: With N in control bits [11:0], every transmitted bit, including the start bit, lasts exactly 16 × (N + 1) clock cycles.
- R3: While control bit 12 is set, txd is held low. When the bit is cleared, txd returns high.
- R4: Control bit 13 enables parity. Control bit 14 = 1 selects even parity and 0 selects odd. The transmitter sends the parity bit after the data bits. The receiver sets bit 9 of the read word when the received parity does not match.
- R5: Control bit 15 = 1 makes the transmitter send two stop bits. With the bit clear it sends one, and a queued next character starts right after that one stop bit.
- R6: Control bits [18:17] set the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits go out least significant first, and received bits above the length read as zero.
- R7: Control bit 16 = 1 gives each queue 16 entries and 0 gives one entry. tx_full rises when the transmit queue reaches that capacity, and a data write to a full queue is dropped.
- R8: A data-port read returns the character in bits [7:0], framing error in bit 8, parity error in bit 9 and overrun in bit 10. It removes that entry, and rx_empty reflects the queue state.
- R9: A character that completes while the receive queue is full is discarded, and bit 10 is set on the newest stored entry.
- R10: busy is high while a character is queued or being shifted out, and it drops only after the last stop bit has ended.
- R11: With en low, no new character starts on txd, which stays high, and the receiver ignores the line.
- R12: tx_irq equals en AND NOT tx_full. rx_irq equals en AND NOT rx_empty.
- R13: A stop bit sampled low sets bit 8 of that character. The receiver then waits for the line to go high before it looks for the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the bit-rate source |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Port enable |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (a data read pops the receive queue) |
| addr | input | 7 | Byte address within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle rd is high |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_empty | output | 1 | Receive queue holds nothing |
| tx_full | output | 1 | Transmit queue at capacity |
| busy | output | 1 | Transmitter has queued or in-flight data |
| tx_irq | output | 1 | Transmit queue has room while enabled |
| rx_irq | output | 1 | Receive queue has data while enabled |

## Verification
The bench sends a seventeenth character into a full receive queue and expects the overrun flag only on the sixteenth entry. A design that wrote the flag at the write pointer, or that overwrote an entry, would return a wrong word or a seventeenth read. It measures the start bit length in clock cycles, so a divisor used as N rather than N + 1 shows up as a short bit. It decodes back-to-back characters at the centre of the would-be second stop bit, which exposes a stop count that ignores its control bit. It also checks 5-bit frames in both directions, deliberate parity and framing faults (including recovery afterwards), and single-entry mode, where a second write or a second character must be dropped rather than queued.

// File: rtl/uart_pkg.sv
// Shared constants, the control-word layout and small helpers for the serial port.
// Assumes a 7-bit byte address window and an 8-bit maximum character.
package uart_pkg;
    localparam int DIV_W  = 12;   // divisor field width
    localparam int CFG_W  = 19;   // stored control bits
    localparam int CHAR_W = 8;    // widest character
    localparam int RXW_W  = CHAR_W + 3; // character plus three flags

    localparam logic [6:0] OFS_DATA = 7'h00;
    localparam logic [6:0] OFS_CTRL = 7'h40;

    // Packed so that the field order matches the control-word bit positions.
    typedef struct packed {
        logic [1:0]       wlen;      // [18:17]
        logic             fifo_on;   // [16]
        logic             two_stop;  // [15]
        logic             even;      // [14]
        logic             par_on;    // [13]
        logic             brk;       // [12]
        logic [DIV_W-1:0] div;       // [11:0]
    } cfg_t;

    // Number of data bits for a length code.
    function automatic logic [3:0] char_bits(input logic [1:0] wl);
        return 4'd5 + {2'b00, wl};
    endfunction

    // Mask of the valid data bits for a length code.
    function automatic logic [7:0] bit_mask(input logic [1:0] wl);
        return 8'hFF >> (2'd3 - wl);
    endfunction
endpackage

// File: rtl/uart_tick.sv
// Oversampling tick generator: one pulse every (limit + 1) clocks.
// A synchronous clear restarts the count so a frame can align to it.
module uart_tick #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          tick
);
    logic [CW-1:0] cnt;

    // Count up to the limit and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      cnt <= '0;
        else if (cnt == limit)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt == limit);
endmodule

// File: rtl/uart_fifo.sv
// Circular queue with a run-time capacity of DEPTH or one entry.
// 'mark' sets the top bit of the newest stored entry (overrun tagging).
// Assumes DEPTH is a power of two, at least 2. A push to a full queue is dropped.
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         deep,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         mark,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] count, cap;
    logic          wr_ok, rd_ok;

    assign cap   = deep ? CW'(DEPTH) : CW'(1);
    assign full  = (count >= cap);
    assign empty = (count == '0);
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign dout  = mem[rp];

    // Storage writes and overrun tagging of the newest entry.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= din;
        if (mark && !empty) mem[wp - 1'b1][W-1] <= 1'b1;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    assert_within_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_pop_removes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/uart_tx.sv
// Transmit shifter: start bit, 5..8 data bits LSB first, optional parity, 1 or 2 stops.
// Loads from the queue only while enabled. Each bit is 16 ticks of a tick generator
// that is restarted on load, so bit edges fall on exact multiples of 16*(N+1) clocks.
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  cfg_t       cfg,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       txd,
    output logic       active
);
    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_t;

    tst_t       state;
    logic [7:0] shreg;
    logic [3:0] sub, bitn;
    logic       pbit, stop2, tick, line;
    logic [7:0] masked;

    assign masked = q_data & bit_mask(cfg.wlen);
    assign q_pop  = (state == T_IDLE) && en && !q_empty;

    uart_tick #(.CW(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == T_IDLE),
        .limit (cfg.div),
        .tick  (tick)
    );

    // Frame sequencing: load on pop, advance one bit every 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= T_IDLE;
            shreg <= '0;
            sub   <= '0;
            bitn  <= '0;
            pbit  <= 1'b0;
            stop2 <= 1'b0;
        end else if (q_pop) begin
            state <= T_START;
            shreg <= masked;
            pbit  <= (^masked) ^ !cfg.even;
            sub   <= '0;
            bitn  <= '0;
            stop2 <= 1'b0;
        end else if (state != T_IDLE && tick) begin
            if (sub != 4'hF) begin
                sub <= sub + 1'b1;
            end else begin
                sub <= '0;
                unique case (state)
                    T_START: state <= T_DATA;
                    T_DATA: begin
                        shreg <= {1'b0, shreg[7:1]};
                        if (bitn == char_bits(cfg.wlen) - 4'd1)
                            state <= cfg.par_on ? T_PAR : T_STOP;
                        else
                            bitn <= bitn + 1'b1;
                    end
                    T_PAR:   state <= T_STOP;
                    T_STOP: begin
                        if (cfg.two_stop && !stop2) stop2 <= 1'b1;
                        else                        state <= T_IDLE;
                    end
                    default: state <= T_IDLE;
                endcase
            end
        end
    end

    // Line level for the current frame position.
    always_comb begin
        unique case (state)
            T_START: line = 1'b0;
            T_DATA:  line = shreg[0];
            T_PAR:   line = pbit;
            default: line = 1'b1;
        endcase
    end

    assign txd    = cfg.brk ? 1'b0 : line;
    assign active = (state != T_IDLE);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (state == T_START && line == 1'b0));

    assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_IDLE && !en) |=> (state == T_IDLE));
endmodule

// File: rtl/uart_rx.sv
// Receive deframer: 16x oversampling, start bit verified at its centre,
// data/parity/stop sampled at bit centres. Emits a one-cycle push with
// {overrun=0, parity_err, frame_err, data}. After a low stop bit it waits for idle.
module uart_rx
    import uart_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  cfg_t             cfg,
    input  logic             rxd,
    output logic             push,
    output logic [RXW_W-1:0] word
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT} rst_t;

    rst_t       state;
    logic       rx_m, rx_s, tick, perr;
    logic [3:0] sub, bitn;
    logic [7:0] data;

    // Two-flop synchroniser for the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    uart_tick #(.CW(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .limit (cfg.div),
        .tick  (tick)
    );

    // Frame capture state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= R_IDLE;
            sub   <= '0;
            bitn  <= '0;
            data  <= '0;
            perr  <= 1'b0;
            push  <= 1'b0;
            word  <= '0;
        end else begin
            push <= 1'b0;
            if (!en) begin
                state <= R_IDLE;
            end else begin
                unique case (state)
                    R_IDLE: if (tick && !rx_s) begin
                        state <= R_START;
                        sub   <= '0;
                    end
                    R_START: if (tick) begin
                        if (sub == 4'd7) begin
                            if (!rx_s) begin
                                state <= R_DATA;
                                sub   <= '0;
                                bitn  <= '0;
                                data  <= '0;
                                perr  <= 1'b0;
                            end else begin
                                state <= R_IDLE;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    R_DATA: if (tick) begin
                        if (sub == 4'hF) begin
                            sub <= '0;
                            data[bitn[2:0]] <= rx_s;
                            if (bitn == char_bits(cfg.wlen) - 4'd1)
                                state <= cfg.par_on ? R_PAR : R_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    R_PAR: if (tick) begin
                        if (sub == 4'hF) begin
                            sub   <= '0;
                            perr  <= (^data) ^ rx_s ^ !cfg.even;
                            state <= R_STOP;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    R_STOP: if (tick) begin
                        if (sub == 4'hF) begin
                            sub   <= '0;
                            push  <= 1'b1;
                            word  <= {1'b0, perr, !rx_s, data};
                            state <= rx_s ? R_IDLE : R_WAIT;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    R_WAIT: if (rx_s) state <= R_IDLE;
                    default: state <= R_IDLE;
                endcase
            end
        end
    end

    assert_frame_wait_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (push && word[8]) |-> (state == R_WAIT));

    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == R_IDLE));
endmodule

// File: rtl/uart_shared_cfg.sv
// Serial port top: control word and data port decode, transmit and receive
// queues, shifters, status and interrupt outputs.
// Assumes single-cycle register access. rdata is combinational and valid while rd is high.
module uart_shared_cfg
    import uart_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        wr,
    input  logic        rd,
    input  logic [6:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        rx_empty,
    output logic        tx_full,
    output logic        busy,
    output logic        tx_irq,
    output logic        rx_irq
);
    cfg_t             cfg;
    logic             sel_data, sel_ctrl;
    logic             txq_empty, tx_pop, tx_active;
    logic [7:0]       txq_dout;
    logic             rx_push, rxq_full;
    logic [RXW_W-1:0] rx_word, rxq_dout;

    assign sel_data = (addr == OFS_DATA);
    assign sel_ctrl = (addr == OFS_CTRL);

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)                cfg <= '0;
        else if (wr && sel_ctrl)   cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end

    uart_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .deep  (cfg.fifo_on),
        .push  (wr && sel_data),
        .din   (wdata[CHAR_W-1:0]),
        .pop   (tx_pop),
        .mark  (1'b0),
        .dout  (txq_dout),
        .empty (txq_empty),
        .full  (tx_full)
    );

    uart_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cfg     (cfg),
        .q_empty (txq_empty),
        .q_data  (txq_dout),
        .q_pop   (tx_pop),
        .txd     (txd),
        .active  (tx_active)
    );

    uart_rx u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .cfg   (cfg),
        .rxd   (rxd),
        .push  (rx_push),
        .word  (rx_word)
    );

    uart_fifo #(.W(RXW_W), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .deep  (cfg.fifo_on),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rd && sel_data),
        .mark  (rx_push && rxq_full),
        .dout  (rxq_dout),
        .empty (rx_empty),
        .full  (rxq_full)
    );

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        if (sel_ctrl)                   rdata = {{(32-CFG_W){1'b0}}, cfg};
        else if (sel_data && !rx_empty) rdata = {{(32-RXW_W){1'b0}}, rxq_dout};
    end

    assign busy   = tx_active || !txq_empty;
    assign tx_irq = en && !tx_full;
    assign rx_irq = en && !rx_empty;
endmodule

// File: tb/uart_shared_cfg_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module uart_shared_cfg_tb;
    logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr = 1'b0, rd = 1'b0, rxd = 1'b1;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        txd, rx_empty, tx_full, busy, tx_irq, rx_irq;
    int          n_chk = 0, n_bad = 0, div_n = 1;

    uart_shared_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .rx_empty(rx_empty),
        .tx_full(tx_full), .busy(busy), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(int n, int wl, bit par, bit ev, bit two, bit fifo, bit brk);
        return (32'(wl) << 17) | (32'(fifo) << 16) | (32'(two) << 15) |
               (32'(ev) << 14) | (32'(par) << 13) | (32'(brk) << 12) | 32'(n);
    endfunction

    task automatic wait_cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(logic [6:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic set_cfg(logic [31:0] v);
        bus_wr(7'h40, v);
        div_n = int'(v[11:0]);
    endtask

    task automatic rx_send(logic [7:0] d, int nb, bit par_on, bit pbit, bit stopv);
        int bp = 16 * (div_n + 1);
        @(negedge clk); rxd = 1'b0; wait_cyc(bp);
        for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_cyc(bp); end
        if (par_on) begin rxd = pbit; wait_cyc(bp); end
        rxd = stopv; wait_cyc(bp);
        rxd = 1'b1; wait_cyc(bp);
    endtask

    task automatic tx_grab(string req, int nb, bit par_on, output logic [7:0] val,
                           output logic pb, output logic s1, output logic s2);
        int bp = 16 * (div_n + 1);
        int t = 0;
        while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        chk({req, " start seen"}, {31'b0, txd}, 32'h0);
        wait_cyc(bp / 2);
        val = '0;
        for (int i = 0; i < nb; i++) begin wait_cyc(bp); val[i] = txd; end
        pb = 1'b0;
        if (par_on) begin wait_cyc(bp); pb = txd; end
        wait_cyc(bp); s1 = txd;
        wait_cyc(bp); s2 = txd;
    endtask

    task automatic wait_idle(string req);
        int t = 0;
        while (busy !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
        chk({req, " busy clears"}, {31'b0, busy}, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R11 txd idle after reset", {31'b0, txd}, 32'h1);
        chk("R8 rx_empty after reset", {31'b0, rx_empty}, 32'h1);
        chk("R7 tx_full after reset", {31'b0, tx_full}, 32'h0);
        chk("R10 busy after reset", {31'b0, busy}, 32'h0);
        chk("R12 irqs after reset", {30'b0, tx_irq, rx_irq}, 32'h0);
        bus_rd(7'h40, d);
        chk("R1 control after reset", d, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_wr(7'h40, 32'hFFFF_FFFF);
        bus_rd(7'h40, d);
        chk("R1 control readback", d, 32'h0007_FFFF);
        set_cfg(mkcfg(1, 3, 0, 0, 0, 1, 0));
        bus_rd(7'h40, d);
        chk("R1 control readback 2", d, 32'h0007_0001);
    endtask

    task automatic t_enable;
        logic [7:0] v; logic pb, s1, s2;
        int lows = 0;
        bus_wr(7'h00, 32'hA5);
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R11 no start while disabled", 32'(lows), 32'h0);
        chk("R10 busy with queued char", {31'b0, busy}, 32'h1);
        rx_send(8'h3C, 8, 0, 0, 1);
        chk("R11 rx ignores line when off", {31'b0, rx_empty}, 32'h1);
        @(negedge clk); en = 1'b1;
        tx_grab("R6", 8, 0, v, pb, s1, s2);
        chk("R6 8-bit char lsb first", {24'b0, v}, 32'hA5);
        chk("R5 one stop high", {31'b0, s1}, 32'h1);
        chk("R10 busy low after stop", {31'b0, busy}, 32'h0);
    endtask

    task automatic t_bitrate;
        int cnt = 0, t = 0;
        set_cfg(mkcfg(2, 3, 0, 0, 0, 1, 0));
        bus_wr(7'h00, 32'h01);
        while (txd !== 1'b0 && t < 1000) begin @(negedge clk); t++; end
        chk("R10 busy during frame", {31'b0, busy}, 32'h1);
        while (txd === 1'b0 && cnt < 1000) begin cnt++; @(negedge clk); end
        chk("R2 start bit length N=2", 32'(cnt), 32'd48);
        wait_idle("R10");
        set_cfg(mkcfg(1, 3, 0, 0, 0, 1, 0));
    endtask

    task automatic t_wordlen;
        logic [7:0] v; logic pb, s1, s2; logic [31:0] d;
        set_cfg(mkcfg(1, 0, 0, 0, 0, 1, 0));
        bus_wr(7'h00, 32'hFF);
        tx_grab("R6", 5, 0, v, pb, s1, s2);
        chk("R6 5-bit tx data", {24'b0, v}, 32'h1F);
        chk("R6 stop follows 5th bit", {31'b0, s1}, 32'h1);
        wait_idle("R6");
        rx_send(8'hFF, 5, 0, 0, 1);
        bus_rd(7'h00, d);
        chk("R6 5-bit rx upper bits zero", d, 32'h1F);
    endtask

    task automatic t_parity;
        logic [7:0] v; logic pb, s1, s2; logic [31:0] d;
        set_cfg(mkcfg(1, 3, 1, 1, 0, 1, 0));
        bus_wr(7'h00, 32'h03);
        tx_grab("R4", 8, 1, v, pb, s1, s2);
        chk("R4 even parity bit", {31'b0, pb}, 32'h0);
        wait_idle("R4");
        set_cfg(mkcfg(1, 3, 1, 0, 0, 1, 0));
        bus_wr(7'h00, 32'h03);
        tx_grab("R4", 8, 1, v, pb, s1, s2);
        chk("R4 odd parity bit", {31'b0, pb}, 32'h1);
        wait_idle("R4");
        set_cfg(mkcfg(1, 3, 1, 1, 0, 1, 0));
        rx_send(8'h03, 8, 1, 1, 1);
        bus_rd(7'h00, d);
        chk("R4 rx parity error flag", d, 32'h203);
        rx_send(8'h03, 8, 1, 0, 1);
        bus_rd(7'h00, d);
        chk("R4 rx parity good", d, 32'h003);
    endtask

    task automatic t_stops;
        logic [7:0] v; logic pb, s1, s2;
        set_cfg(mkcfg(1, 3, 0, 0, 1, 1, 0));
        bus_wr(7'h00, 32'h00);
        bus_wr(7'h00, 32'h00);
        tx_grab("R5", 8, 0, v, pb, s1, s2);
        chk("R5 two stops: first", {31'b0, s1}, 32'h1);
        chk("R5 two stops: second", {31'b0, s2}, 32'h1);
        wait_idle("R5");
        set_cfg(mkcfg(1, 3, 0, 0, 0, 1, 0));
        bus_wr(7'h00, 32'h00);
        bus_wr(7'h00, 32'h00);
        tx_grab("R5", 8, 0, v, pb, s1, s2);
        chk("R5 one stop then next start", {31'b0, s2}, 32'h0);
        wait_idle("R5");
    endtask

    task automatic t_break;
        set_cfg(mkcfg(1, 3, 0, 0, 0, 1, 1));
        chk("R3 break drives low", {31'b0, txd}, 32'h0);
        wait_cyc(50);
        chk("R3 break held", {31'b0, txd}, 32'h0);
        set_cfg(mkcfg(1, 3, 0, 0, 0, 1, 0));
        chk("R3 break released", {31'b0, txd}, 32'h1);
    endtask

    task automatic t_rx_basic;
        logic [31:0] d;
        rx_send(8'h5A, 8, 0, 0, 1);
        chk("R8 rx_empty after char", {31'b0, rx_empty}, 32'h0);
        chk("R12 rx_irq with data", {31'b0, rx_irq}, 32'h1);
        bus_rd(7'h00, d);
        chk("R8 rx data word", d, 32'h5A);
        chk("R8 rx_empty after pop", {31'b0, rx_empty}, 32'h1);
        chk("R12 rx_irq cleared", {31'b0, rx_irq}, 32'h0);
    endtask

    task automatic t_frame;
        logic [31:0] d;
        rx_send(8'h81, 8, 0, 0, 0);
        bus_rd(7'h00, d);
        chk("R13 framing flag", d, 32'h181);
        rx_send(8'h42, 8, 0, 0, 1);
        bus_rd(7'h00, d);
        chk("R13 recovery after framing error", d, 32'h042);
        chk("R13 nothing extra queued", {31'b0, rx_empty}, 32'h1);
    endtask

    task automatic t_overrun;
        logic [31:0] d;
        for (int i = 0; i < 17; i++) rx_send(8'(8'h10 + i), 8, 0, 0, 1);
        for (int i = 0; i < 16; i++) begin
            bus_rd(7'h00, d);
            chk("R9 overrun queue entry", d, (i == 15) ? 32'(12'h400 + 8'h10 + i) : 32'(8'h10 + i));
        end
        chk("R9 seventeenth dropped", {31'b0, rx_empty}, 32'h1);
        set_cfg(mkcfg(1, 3, 0, 0, 0, 0, 0));
        rx_send(8'h33, 8, 0, 0, 1);
        rx_send(8'h44, 8, 0, 0, 1);
        bus_rd(7'h00, d);
        chk("R9 single-entry overrun", d, 32'h433);
        chk("R7 single-entry rx holds one", {31'b0, rx_empty}, 32'h1);
    endtask

    task automatic t_txfull;
        logic [7:0] v; logic pb, s1, s2;
        @(negedge clk); en = 1'b0;
        set_cfg(mkcfg(1, 3, 0, 0, 0, 0, 0));
        bus_wr(7'h00, 32'h11);
        chk("R7 single-entry tx full", {31'b0, tx_full}, 32'h1);
        bus_wr(7'h00, 32'h22);
        @(negedge clk); en = 1'b1;
        tx_grab("R7", 8, 0, v, pb, s1, s2);
        chk("R7 first char sent", {24'b0, v}, 32'h11);
        chk("R7 write to full dropped", {31'b0, busy}, 32'h0);
        chk("R12 tx_irq with room", {31'b0, tx_irq}, 32'h1);
        @(negedge clk); en = 1'b0;
        set_cfg(mkcfg(1, 3, 0, 0, 0, 1, 0));
        for (int i = 0; i < 15; i++) bus_wr(7'h00, 32'(i));
        chk("R7 15 entries not full", {31'b0, tx_full}, 32'h0);
        bus_wr(7'h00, 32'h0F);
        chk("R7 16 entries full", {31'b0, tx_full}, 32'h1);
        @(negedge clk); en = 1'b1;
        #1 chk("R12 tx_irq low while full", {31'b0, tx_irq}, 32'h0);
        wait_cyc(2);
        chk("R12 tx_irq after pop", {31'b0, tx_irq}, 32'h1);
        wait_idle("R7");
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_regs();
        t_enable();
        t_bitrate();
        t_wordlen();
        t_parity();
        t_stops();
        t_break();
        t_rx_basic();
        t_frame();
        t_overrun();
        t_txfull();
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end
endmodule